// File: doc/BRIEF.md
# Output-Enable Register Slave on a Two-Wire Serial Bus

This block lets a bus master on a two-wire serial bus (SCL, SDA) set and read back a single byte that decides which of eight clock outputs are switched off. The transfer carries no register-address byte: after the device address the master writes or reads that byte directly. SCL and SDA are brought into a faster system clock domain, and the block finds the START, repeated START and STOP conditions there. It matches a 7-bit device address, acknowledges, and returns data on reads. The SDA pin is open-drain, so the block does not drive a level. It gives one output that, when high, pulls the line low.

Bit n of the byte controls output n, and a 1 turns that output off. On reset every bit is 1, so every output starts disabled. A byte the master writes is held aside and reaches the output gating only when the STOP that ends the write arrives. A repeated START throws the held byte away. The system clock must run at eight or more times the SCL rate, and SCL rates up to 400 kHz are supported.

Top module: `i2coe_slave`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_dis_o` is 8'hFF and `sda_oe_o` is 0.
- R2: The device address, MSB first, is 1,1,0,1,0 followed by `adr_i[1]` and `adr_i[0]`, and the eighth bit is R/W (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: After an address that does not match, the block leaves SDA released until the next START. This covers the address ACK slot and the ACK slot of any following byte. The register stays unchanged.
- R4: On a write, the block shifts in the data byte MSB first and acknowledges it during the ninth SCL pulse.
- R5: `out_dis_o` takes the written byte only after the STOP (SDA rising while SCL is high) that ends the write. It is unchanged at every earlier cycle of the transfer.
- R6: On a read, the block returns the committed register MSB first. It pulls SDA low for a 0 bit and releases it for a 1 bit, changing the line only while SCL is low.
- R7: A START (SDA falling while SCL is high) seen at any point restarts address reception. Any written byte that has not yet been committed is discarded.
- R8: `out_dis_o[n]` is the disable of output n. A 1 means output n is off and a 0 means it is on.
- R9: After the eighth read bit, the block releases SDA for the master's acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| adr_i | input | 2 | Two pin-selected low address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| out_dis_o | output | 8 | Per-output disable; 1 = output off |

## Verification
When the address ACK slot of a read ends, two things happen on the same SCL falling edge: the acknowledge drive is released and the first data bit starts to be driven. On that edge `sda_oe_o` goes straight from ACK-low to the level of register bit 7. The bench provokes this by reading the register once with bit 7 at 0 and once with bit 7 at 1. It judges the result by sampling SDA during each following SCL high phase and comparing the bits with the byte it expects. On every clock it also compares `out_dis_o` with a behavioural model of the committed register.

// File: rtl/i2coe_pkg.sv
package i2coe_pkg;

    localparam int DW        = 8;
    localparam int AW        = 7;
    localparam int PINS      = 2;
    localparam int CNTW      = $clog2(DW + 1);
    localparam logic [AW-PINS-1:0] ADDR_FIXED = 5'b11010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bus_state_t;

    function automatic logic addr_match(input logic [AW-1:0] a,
                                        input logic [PINS-1:0] pins);
        return a == {ADDR_FIXED, pins};
    endfunction

endpackage

// File: rtl/i2coe_sync.sv
module i2coe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b1;
        else     chain[0] <= din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign lvl  = chain[STAGES-1];
    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/i2coe_ctrl.sv
module i2coe_ctrl
    import i2coe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                sda_lvl,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [PINS-1:0]     adr,
    input  logic [DW-1:0]       reg_q,
    output logic                drive_low,
    output logic                commit,
    output logic [DW-1:0]       pend_data
);
    bus_state_t      state;
    logic [CNTW-1:0] cnt;
    logic [DW-1:0]   shreg;
    logic [DW-1:0]   rdbuf;
    logic            rw;
    logic            pend_v;

    assign commit = stop_det & pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            rdbuf     <= '0;
            rw        <= 1'b0;
            pend_v    <= 1'b0;
            pend_data <= '1;
            drive_low <= 1'b0;
        end else if (start_det) begin
            state     <= ST_ADDR;
            cnt       <= '0;
            pend_v    <= 1'b0;
            drive_low <= 1'b0;
        end else if (stop_det) begin
            state     <= ST_IDLE;
            pend_v    <= 1'b0;
            drive_low <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg <= {shreg[DW-2:0], sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end else if (scl_fall && cnt == CNTW'(DW)) begin
                        cnt <= '0;
                        if (state == ST_WDATA) begin
                            pend_data <= shreg;
                            pend_v    <= 1'b1;
                            drive_low <= 1'b1;
                            state     <= ST_WACK;
                        end else if (addr_match(shreg[DW-1:1], adr)) begin
                            rw        <= shreg[0];
                            drive_low <= 1'b1;
                            state     <= ST_AACK;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            rdbuf     <= {reg_q[DW-2:0], 1'b0};
                            drive_low <= ~reg_q[DW-1];
                            state     <= ST_RDATA;
                        end else begin
                            drive_low <= 1'b0;
                            state     <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNTW'(DW - 1)) begin
                            drive_low <= 1'b0;
                            state     <= ST_RACK;
                        end else begin
                            drive_low <= ~rdbuf[DW-1];
                            rdbuf     <= {rdbuf[DW-2:0], 1'b0};
                        end
                    end
                end
                ST_WACK, ST_RACK: begin
                    if (scl_fall) begin
                        drive_low <= 1'b0;
                        state     <= ST_IGNORE;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    restart_addr_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_ADDR) && !pend_v && (cnt == '0));

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !drive_low);

    // R6
    drive_slot_chk: assert property (@(posedge clk) disable iff (rst)
        drive_low |-> (state inside {ST_AACK, ST_WACK, ST_RDATA}));

    // R9
    rack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RACK) |-> !drive_low);
endmodule

// File: rtl/i2coe_slave.sv
module i2coe_slave
    import i2coe_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [1:0]      adr_i,
    output logic            sda_oe_o,
    output logic [7:0]      out_dis_o
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    logic start_det, stop_det, commit;
    logic [DW-1:0] pend_data;
    logic [DW-1:0] dis_q;

    i2coe_sync #(.STAGES(2)) u_scl (
        .clk(clk), .rst(rst), .din(scl_i),
        .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    i2coe_sync #(.STAGES(2)) u_sda (
        .clk(clk), .rst(rst), .din(sda_i),
        .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;

    i2coe_ctrl u_ctrl (
        .clk(clk), .rst(rst),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .start_det(start_det), .stop_det(stop_det),
        .adr(adr_i), .reg_q(dis_q),
        .drive_low(sda_oe_o), .commit(commit), .pend_data(pend_data)
    );

    always_ff @(posedge clk) begin
        if (rst)         dis_q <= '1;
        else if (commit) dis_q <= pend_data;
    end

    assign out_dis_o = dis_q;

    // R5
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (dis_q != $past(dis_q)) |-> $past(stop_det));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (out_dis_o == '1) && !sda_oe_o);
endmodule

// File: tb/sim_i2coe_slave.sv
`timescale 1ns/1ps
module sim_i2coe_slave;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] adr = 2'b10;
    logic       sda_oe;
    logic [7:0] out_dis;
    wire        sda_bus = sda_m & ~sda_oe;

    int         checks = 0;
    int         errors = 0;
    logic [7:0] exp_dis = 8'hFF;
    logic       busy = 1'b1;
    logic       done = 1'b0;

    always #4 clk = ~clk;

    i2coe_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
        .adr_i(adr), .sda_oe_o(sda_oe), .out_dis_o(out_dis)
    );

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R5 R8: committed register compared each clock against the model
    always @(negedge clk) begin
        if (!rst && !busy) begin
            checks++;
            if (out_dis !== exp_dis) begin
                errors++;
                $display("FAIL R5/R8 out_dis actual=%0h expected=%0h", out_dis, exp_dis);
            end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitc(H);
        scl = 1'b1;   waitc(H);
        sda_m = 1'b0; waitc(H);
        scl = 1'b0;   waitc(H);
    endtask

    task automatic bus_stop(input logic [7:0] new_dis);
        sda_m = 1'b0; waitc(H);
        scl = 1'b1;   waitc(H);
        busy = 1'b1;
        sda_m = 1'b1; waitc(6);
        exp_dis = new_dis;
        busy = 1'b0;  waitc(H);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;  waitc(H);
        scl = 1'b1; waitc(H);
        scl = 1'b0;
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; waitc(H);
        scl = 1'b1;   waitc(H / 2);
        b = sda_bus;  waitc(H / 2);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] d, output logic released);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        recv_bit(b);          // master NACK slot: line must stay high
        released = b;
    endtask

    function automatic logic [7:0] dev(input logic [1:0] p, input logic r);
        return {5'b11010, p, r};
    endfunction

    initial begin
        logic       ack;
        logic       rel;
        logic [7:0] rd;

        waitc(4);
        chk(out_dis == 8'hFF, "R1 reset out_dis", out_dis, 8'hFF);
        chk(sda_oe == 1'b0,   "R1 reset sda_oe", sda_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_dis == 8'hFF && sda_oe == 1'b0, "R1 after reset", {out_dis, 7'b0, sda_oe}, 32'hFF00);
        busy = 1'b0;
        waitc(H);

        // R2 R4 R5: write 0x5A, commit only at STOP
        bus_start();
        send_byte(dev(2'b10, 1'b0), ack); chk(ack, "R2 addr ack", ack, 1);
        send_byte(8'h5A, ack);            chk(ack, "R4 data ack", ack, 1);
        chk(out_dis == 8'hFF, "R5 before stop", out_dis, 8'hFF);
        bus_stop(8'h5A);
        chk(out_dis == 8'h5A, "R5 after stop", out_dis, 8'h5A);

        // R6 R9: read back, bit7 = 0 after ACK handoff
        bus_start();
        send_byte(dev(2'b10, 1'b1), ack); chk(ack, "R2 read addr ack", ack, 1);
        read_byte(rd, rel);
        chk(rd == 8'h5A, "R6 read data", rd, 8'h5A);
        chk(rel, "R9 release for master ack", rel, 1);
        bus_stop(8'h5A);

        // R3: wrong address, data byte not acked, register kept
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack); chk(!ack, "R3 mismatch no ack", ack, 0);
        send_byte(8'h00, ack);            chk(!ack, "R3 data ignored", ack, 0);
        bus_stop(8'h5A);
        chk(out_dis == 8'h5A, "R3 register kept", out_dis, 8'h5A);

        // R7: uncommitted write dropped by repeated START, then read
        bus_start();
        send_byte(dev(2'b10, 1'b0), ack); chk(ack, "R7 addr ack", ack, 1);
        send_byte(8'h00, ack);            chk(ack, "R7 data ack", ack, 1);
        bus_start();
        send_byte(dev(2'b10, 1'b1), ack); chk(ack, "R7 restart addr ack", ack, 1);
        read_byte(rd, rel);
        chk(rd == 8'h5A, "R7 discarded write", rd, 8'h5A);
        bus_stop(8'h5A);

        // R2: pins change address; old address refused
        adr = 2'b01;
        waitc(H);
        bus_start();
        send_byte(dev(2'b10, 1'b0), ack); chk(!ack, "R2 old addr refused", ack, 0);
        bus_stop(8'h5A);
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack); chk(ack, "R2 new addr ack", ack, 1);
        send_byte(8'hBC, ack);            chk(ack, "R4 data ack 2", ack, 1);
        bus_stop(8'hBC);

        // R6: read with bit7 = 1 after ACK handoff
        bus_start();
        send_byte(dev(2'b01, 1'b1), ack); chk(ack, "R6 addr ack", ack, 1);
        read_byte(rd, rel);
        chk(rd == 8'hBC, "R6 read bit7 one", rd, 8'hBC);
        chk(rel, "R9 release 2", rel, 1);
        bus_stop(8'hBC);

        // R8: all outputs on
        bus_start();
        send_byte(dev(2'b01, 1'b0), ack); chk(ack, "R8 addr ack", ack, 1);
        send_byte(8'h00, ack);            chk(ack, "R8 data ack", ack, 1);
        bus_stop(8'h00);
        chk(out_dis == 8'h00, "R8 all enabled", out_dis, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule